// File: doc/BRIEF.md
# Programmable Pin Logic Fabric

This block sits between an 8-bit I/O port and the on-chip peripherals that use it. It holds eight small lookup tables, each with three inputs. A per-input routing field picks the source of every input: a port pin, a peripheral output, or the registered output of any table. The result replaces the signal on the outbound path (peripheral to pin), on the inbound path (pin to peripheral), or on both. Glue logic such as gates, clock inversion, clock division and clock replication can therefore be built on the port without any board-level parts.

The fabric needs nothing from the processor once it is configured, so it keeps working while the core sleeps. A rising edge on one chosen table output can raise a sticky wake flag. Configuration is a simple write port with one word per table, one control word and one clear address. All registers use an asynchronous active-low reset that is released in step with the clock.

Top module: `pin_logic_fabric`

## Requirements
- R1: After reset every table word and the control word are zero, so the fabric is disabled: `pin_out` equals `periph_out`, `periph_in` equals `pin_in`, and `wake_irq` is 0.
- R2: Table word *i* (address *i*, 0 to 7) holds the truth table in bits [7:0]. A table's combinational output is bit `{in2,in1,in0}` of that field, where in0 is the least significant index bit.
- R3: Each table input has a 5-bit source code: in0 in bits [12:8], in1 in [17:13], in2 in [22:18]. Codes 0–7 select `pin_in[code]`, 8–15 select `periph_out[code-8]`, 16–23 select the registered output of table `code-16`, and 24–31 select constant 0.
- R4: Each table owns a flip-flop that loads the table's combinational output on every clock while the fabric is enabled. Feedback sources always read this flip-flop, so a table that inverts its own registered output toggles on each clock. Bit 23 of the table word makes the table's output the flip-flop value instead of the combinational value, which delays it by one clock.
- R5: On the outbound path, with the fabric enabled and bit 24 of table word *i* clear, `pin_out[i]` is table *i*'s output. With bit 24 set it is `periph_out[i]`.
- R6: On the inbound path, with the fabric enabled and bit 25 of table word *i* clear, `periph_in[i]` is table *i*'s output. With bit 25 set it is `pin_in[i]`.
- R7: The control word at address 8 has the fabric enable in bit 0. While that bit is 0, both paths are bypassed for every pin, whatever the table words hold.
- R8: Control bits [3:1] pick the watched table and bit 4 enables waking. When waking and the fabric are enabled, a 0-to-1 change of the watched table's output sets `wake_irq` at the next clock edge. A falling edge does not set it, and nothing sets it while waking is disabled.
- R9: `wake_irq` stays set until a write of 1 to bit 0 at address 9 clears it. If a new rising edge is seen in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: 0–7 table words, 8 control, 9 wake clear |
| cfg_wdata | input | 26 | Configuration write data |
| pin_in | input | 8 | Values arriving from the port pins |
| periph_out | input | 8 | Values produced by the peripherals |
| pin_out | output | 8 | Values driven to the port pins |
| periph_in | output | 8 | Values delivered to the peripherals |
| wake_irq | output | 1 | Sticky wake interrupt flag |

## Verification
Every table, input slot and non-feedback source code is swept. The other sources are held at the opposite value, so a routing decoder that picks the wrong index or the wrong source group flips the output. The codes beyond 23 are driven with all other sources high, which catches a decoder that wraps them onto a real signal. A self-inverting feedback table must alternate on every clock; a design that fed back the combinational value would loop or stall. The wake flag is tested for set-on-rise, hold after the signal falls, no set on a falling edge, no set while waking is disabled, and set winning over a clear in the same cycle. A design that let the clear win would drop an edge there.

// File: rtl/plf_pkg.sv
package plf_pkg;
  // Number of inputs per lookup table and the truth-table width it implies.
  localparam int LUT_K = 3;
  localparam int TT_W  = 1 << LUT_K;

  // Low bit of input slot k's source code inside a table word.
  function automatic int sel_lo(input int k, input int src_w);
    return TT_W + k * src_w;
  endfunction
endpackage

// File: rtl/plf_rst_sync.sv
module plf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/plf_cfg.sv
module plf_cfg #(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 4,
  parameter int WORD_W = 26,
  parameter int SELW_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [WORD_W-1:0]        cfg_wdata,
  output logic [N_CH*WORD_W-1:0]   lut_cfg,
  output logic                     fab_en,
  output logic                     wake_en,
  output logic [SELW_W-1:0]        wake_sel,
  output logic                     wake_clr
);
  localparam int CTRL_ADDR = N_CH;
  localparam int CLR_ADDR  = N_CH + 1;
  localparam int CTRL_W    = SELW_W + 2;

  for (genvar i = 0; i < N_CH; i++) begin : g_word
    logic              ld;
    logic [WORD_W-1:0] word_q;

    assign ld = cfg_we && (cfg_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (ld) word_q <= cfg_wdata;
    end

    assign lut_cfg[i*WORD_W +: WORD_W] = word_q;
  end

  logic              ctrl_ld;
  logic [CTRL_W-1:0] ctrl_q;

  assign ctrl_ld = cfg_we && (cfg_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ld) ctrl_q <= cfg_wdata[CTRL_W-1:0];
  end

  assign fab_en   = ctrl_q[0];
  assign wake_sel = ctrl_q[SELW_W:1];
  assign wake_en  = ctrl_q[SELW_W+1];
  assign wake_clr = cfg_we && (cfg_addr == ADDR_W'(CLR_ADDR)) && cfg_wdata[0];

  // R7: after a control write, the enable follows the written bit.
  p_ctrl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ld |=> (fab_en == $past(cfg_wdata[0])));
endmodule

// File: rtl/plf_lut_cell.sv
module plf_lut_cell #(
  parameter int N_CH  = 8,
  parameter int SRC_W = 5,
  parameter int LUT_K = 3,
  parameter int TT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic [TT_W-1:0]        tt,
  input  logic [LUT_K*SRC_W-1:0] sel,
  input  logic                   ff_en,
  input  logic [N_CH-1:0]        pin_in,
  input  logic [N_CH-1:0]        periph_out,
  input  logic [N_CH-1:0]        fb_q,
  output logic                   lut_out,
  output logic                   q
);
  logic [SRC_W-1:0] sel_k [LUT_K];
  logic [LUT_K-1:0] in_v;
  logic             comb_out;
  logic             q_d;

  for (genvar k = 0; k < LUT_K; k++) begin : g_slot
    assign sel_k[k] = sel[k*SRC_W +: SRC_W];

    always_comb begin
      in_v[k] = 1'b0;
      for (int j = 0; j < N_CH; j++) begin
        if (sel_k[k] == SRC_W'(j))          in_v[k] = pin_in[j];
        if (sel_k[k] == SRC_W'(N_CH + j))   in_v[k] = periph_out[j];
        if (sel_k[k] == SRC_W'(2*N_CH + j)) in_v[k] = fb_q[j];
      end
    end
  end

  assign comb_out = tt[in_v];

  always_comb begin
    q_d = q;
    if (ce) q_d = comb_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  assign lut_out = ff_en ? q : comb_out;

  // R4: the feedback flop captures the table result on each enabled clock.
  p_fb_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q == $past(comb_out)));
  // R4: with the fabric stopped the flop holds its value.
  p_fb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q));
endmodule

// File: rtl/plf_wake.sv
module plf_wake #(
  parameter int N_CH   = 8,
  parameter int SELW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   lut_out,
  input  logic              fab_en,
  input  logic              wake_en,
  input  logic [SELW_W-1:0] wake_sel,
  input  logic              wake_clr,
  output logic              wake_irq
);
  logic watched;
  logic prev_q, prev_d;
  logic irq_q, irq_d;
  logic rise;

  assign watched = lut_out[wake_sel];
  assign rise    = watched && !prev_q && wake_en && fab_en;

  always_comb begin
    prev_d = watched;
    irq_d  = irq_q;
    if (wake_clr) irq_d = 1'b0;
    if (rise)     irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      irq_q  <= irq_d;
    end
  end

  assign wake_irq = irq_q;

  // R8: a qualified rising edge sets the flag on the next clock.
  p_rise_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> wake_irq);
  // R8: the flag never rises unless waking was enabled.
  p_rise_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(wake_en && fab_en));
  // R9: without a clear the flag holds.
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !wake_clr) |=> wake_irq);
endmodule

// File: rtl/pin_logic_fabric.sv
module pin_logic_fabric #(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [plf_pkg::TT_W+3*$clog2(3*N_CH+1)+2:0] cfg_wdata,
  input  logic [N_CH-1:0]     pin_in,
  input  logic [N_CH-1:0]     periph_out,
  output logic [N_CH-1:0]     pin_out,
  output logic [N_CH-1:0]     periph_in,
  output logic                wake_irq
);
  import plf_pkg::*;

  localparam int SRC_W  = $clog2(3*N_CH + 1);
  localparam int SEL_W  = LUT_K * SRC_W;
  localparam int FF_BIT = TT_W + SEL_W;
  localparam int PB_BIT = FF_BIT + 1;
  localparam int QB_BIT = FF_BIT + 2;
  localparam int WORD_W = QB_BIT + 1;
  localparam int SELW_W = $clog2(N_CH);

  logic                   rst_s_n;
  logic [N_CH*WORD_W-1:0] lut_cfg;
  logic                   fab_en;
  logic                   wake_en;
  logic [SELW_W-1:0]      wake_sel;
  logic                   wake_clr;
  logic [N_CH-1:0]        lut_out;
  logic [N_CH-1:0]        lut_q;

  plf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  plf_cfg #(
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .SELW_W (SELW_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lut_cfg   (lut_cfg),
    .fab_en    (fab_en),
    .wake_en   (wake_en),
    .wake_sel  (wake_sel),
    .wake_clr  (wake_clr)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [WORD_W-1:0] word;
    logic              out_byp;
    logic              in_byp;

    assign word    = lut_cfg[i*WORD_W +: WORD_W];
    assign out_byp = !fab_en || word[PB_BIT];
    assign in_byp  = !fab_en || word[QB_BIT];

    plf_lut_cell #(
      .N_CH  (N_CH),
      .SRC_W (SRC_W),
      .LUT_K (LUT_K),
      .TT_W  (TT_W)
    ) u_cell (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .ce         (fab_en),
      .tt         (word[TT_W-1:0]),
      .sel        (word[sel_lo(0, SRC_W) +: SEL_W]),
      .ff_en      (word[FF_BIT]),
      .pin_in     (pin_in),
      .periph_out (periph_out),
      .fb_q       (lut_q),
      .lut_out    (lut_out[i]),
      .q          (lut_q[i])
    );

    assign pin_out[i]   = out_byp ? periph_out[i] : lut_out[i];
    assign periph_in[i] = in_byp  ? pin_in[i]     : lut_out[i];
  end

  plf_wake #(
    .N_CH   (N_CH),
    .SELW_W (SELW_W)
  ) u_wake (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .lut_out  (lut_out),
    .fab_en   (fab_en),
    .wake_en  (wake_en),
    .wake_sel (wake_sel),
    .wake_clr (wake_clr),
    .wake_irq (wake_irq)
  );

  // R7: with the fabric disabled both paths are plain feed-throughs.
  p_out_bypass_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fab_en |-> (pin_out == periph_out));
  p_in_bypass_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fab_en |-> (periph_in == pin_in));
  // R1: the flag is clear on the first cycle out of reset.
  p_reset_flag_r1: assert property (@(posedge clk)
    $rose(rst_s_n) |-> !wake_irq);
endmodule

// File: tb/test_pin_logic_fabric.sv
module test_pin_logic_fabric;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [25:0] cfg_wdata;
  logic [7:0]  pin_in, periph_out;
  logic [7:0]  pin_out, periph_in;
  logic        wake_irq;

  int test_cnt = 0;
  int fail_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_logic_fabric i_pin_logic_fabric (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_in(pin_in), .periph_out(periph_out),
    .pin_out(pin_out), .periph_in(periph_in), .wake_irq(wake_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    test_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input logic [7:0] tt, input int s0, input int s1,
                                     input int s2, input bit ff, input bit pb, input bit qb);
    return {qb, pb, ff, 5'(s2), 5'(s1), 5'(s0), tt};
  endfunction

  function automatic logic [25:0] ctrl(input bit en, input int sel, input bit wen);
    return 26'({wen, 3'(sel), en});
  endfunction

  task automatic wr(input int a, input logic [25:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] tts [6] = '{8'h80, 8'hFE, 8'h96, 8'h6A, 8'h01, 8'hC3};
    logic [7:0] slot_tt [3] = '{8'hAA, 8'hCC, 8'hF0};
    logic prev;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pin_in = '0; periph_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state is full bypass, flag clear
    for (int p = 0; p < 4; p++) begin
      pin_in = 8'(p * 8'h5B + 8'h13); periph_out = 8'(~(p * 8'h37));
      #1;
      chk("R1 pin_out", pin_out, periph_out);
      chk("R1 periph_in", periph_in, pin_in);
      chk("R1 wake_irq", 8'(wake_irq), 8'h0);
    end

    wr(8, ctrl(1, 0, 0));

    // R2: truth table sweep on table 3 fed from pins 0..2
    for (int t = 0; t < 6; t++) begin
      wr(3, mk(tts[t], 0, 1, 2, 0, 0, 0));
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        pin_in = 8'(c); #1;
        chk("R2 truth table", 8'(pin_out[3]), 8'((tts[t] >> c) & 1));
      end
    end

    // R3/R5/R6: routing sweep over pin and peripheral sources
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 16; s++) begin
          wr(i, mk(slot_tt[k], (k == 0) ? s : 24, (k == 1) ? s : 24, (k == 2) ? s : 24, 0, 0, 0));
          for (int v = 0; v < 2; v++) begin
            logic [7:0] pat;
            pat = v ? (8'h01 << (s % 8)) : ~(8'h01 << (s % 8));
            @(negedge clk);
            if (s < 8) begin pin_in = pat; periph_out = ~pat; end
            else       begin periph_out = pat; pin_in = ~pat; end
            #1;
            chk("R3 R5 routed pin_out", 8'(pin_out[i]), 8'(v));
            chk("R3 R6 routed periph_in", 8'(periph_in[i]), 8'(v));
          end
        end

    // R3: codes 24..31 read constant zero
    pin_in = '1; periph_out = '1;
    for (int s = 24; s < 32; s++) begin
      wr(7, mk(8'hAA, s, 24, 24, 0, 0, 0));
      #1;
      chk("R3 const zero source", 8'(pin_out[7]), 8'h0);
    end

    // R4: self-inverting feedback toggles; table 5 mirrors the flop of table 4
    wr(4, mk(8'h55, 20, 24, 24, 1, 0, 0));
    wr(5, mk(8'hAA, 20, 24, 24, 0, 0, 0));
    #1; prev = pin_out[4];
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); #1;
      chk("R4 feedback toggle", 8'(pin_out[4]), 8'(~prev & 1'b1));
      chk("R4 feedback source", 8'(pin_out[5]), 8'(pin_out[4]));
      prev = pin_out[4];
    end

    // R4: registered output lags by one clock
    pin_in = '0;
    wr(6, mk(8'hAA, 6, 24, 24, 1, 0, 0));
    @(negedge clk);
    pin_in[6] = 1'b1; #1;
    chk("R4 registered old value", 8'(pin_out[6]), 8'h0);
    @(negedge clk); #1;
    chk("R4 registered new value", 8'(pin_out[6]), 8'h1);

    // R5/R6: per-pin bypass bits
    wr(1, mk(8'hFF, 24, 24, 24, 0, 1, 0));
    @(negedge clk); periph_out = 8'h00; pin_in = 8'h00; #1;
    chk("R5 outbound bypass", 8'(pin_out[1]), 8'h0);
    chk("R6 inbound via table", 8'(periph_in[1]), 8'h1);
    wr(1, mk(8'hFF, 24, 24, 24, 0, 0, 1));
    #1;
    chk("R5 outbound via table", 8'(pin_out[1]), 8'h1);
    chk("R6 inbound bypass", 8'(periph_in[1]), 8'h0);

    // R7: global disable forces bypass everywhere
    wr(0, mk(8'hFF, 24, 24, 24, 0, 0, 0));
    #1; chk("R7 enabled table drives", 8'(pin_out[0]), 8'h1);
    wr(8, ctrl(0, 0, 0));
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      pin_in = 8'(8'hA5 ^ (p * 8'h31)); periph_out = 8'(8'h3C + p * 8'h19); #1;
      chk("R7 disabled pin_out", pin_out, periph_out);
      chk("R7 disabled periph_in", periph_in, pin_in);
    end

    // R8/R9: wake on table 2 fed from pin 5
    pin_in = '0;
    wr(2, mk(8'hAA, 5, 24, 24, 0, 0, 0));
    wr(8, ctrl(1, 2, 1));
    @(negedge clk); #1;
    chk("R8 no edge no flag", 8'(wake_irq), 8'h0);
    pin_in[5] = 1'b1; #1;
    chk("R8 flag not before edge", 8'(wake_irq), 8'h0);
    @(negedge clk); #1;
    chk("R8 rising edge sets", 8'(wake_irq), 8'h1);
    pin_in[5] = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R9 flag sticky", 8'(wake_irq), 8'h1);
    wr(9, 26'h1); #1;
    chk("R9 clear", 8'(wake_irq), 8'h0);
    pin_in[5] = 1'b1;
    @(negedge clk);
    wr(9, 26'h1);
    pin_in[5] = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk("R8 falling edge ignored", 8'(wake_irq), 8'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 26'h1; pin_in[5] = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; #1;
    chk("R9 set wins over clear", 8'(wake_irq), 8'h1);
    pin_in[5] = 1'b0;
    wr(9, 26'h1);
    wr(8, ctrl(1, 2, 0));
    @(negedge clk); pin_in[5] = 1'b1;
    repeat (2) @(negedge clk); #1;
    chk("R8 waking disabled", 8'(wake_irq), 8'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
    $finish;
  end
endmodule